// File: doc/BRIEF.md
# Defect-Map Segment Allocator

This block walks the defect bitmap of a memory cell array and divides it into segments, one for each logical data block. For every segment it picks, from an eight-entry table of error-correcting codes, the code with the least redundancy that still covers two things: the defective cells inside the segment and a fixed extra allowance for transient errors. The choice of code and the placement of the segment are made together. A stronger code lengthens the segment by its redundancy, and a longer segment can take in more defects, so the engine repeats the choice until it settles.

A run begins with a `start` pulse. Each accepted segment is written as one configuration record to an external RAM. The record holds the segment head, which is always a multiple of the bitmap word width, stored as a word index, together with the index of the chosen code. When no code in the table is strong enough, the segment head is moved to the next word boundary past the first defective cell. The run ends, and `done` rises, as soon as a segment would run past the end of the array or the head reaches the end.

Top module: `segment_allocator`

## Requirements
- R1: After reset `done` and `cfgWe` are low. `done` rises when a run ends and stays high, with no further writes, until the next `start`.
- R2: Records are written to `cfgAddr` 0, 1, 2, … in order. `cfgData` is `{head word index, code index}`, with the code index in the low 3 bits. The head cell address equals the word index times the word width (64).
- R3: The first attempt of a run starts at cell 0. After a segment is accepted, the next head is the segment end rounded up to the next multiple of 64 cells.
- R4: When a code must be selected, the engine takes the code with the smallest redundancy whose t is at least (defects + margin). Among codes of equal redundancy, the lowest index wins. This holds even when redundancy does not grow with t across the table.
- R5: If (defects + margin) is 0 for a segment of length `userLen`, the segment is accepted with code index 0 and no code is selected.
- R6: If (defects + margin) exceeds the largest t in the table, no record is written. The head moves to the word boundary just after the first defective cell at or after the head.
- R7: A segment whose end would pass the last cell is not written, and the run ends. A segment that ends exactly on the last cell is written.
- R8: Each recorded segment is `userLen` plus the chosen code's redundancy cells long, or `userLen` long under R5. Its defect count plus margin does not exceed that code's t.
- R9: Defects are counted on cells from the head up to, but not including, the segment end. A defect on the first cell past the end does not count.
- R10: The bitmap read port is combinational. Bit b of the word at `rdAddr` w describes cell w·64+b, and 1 marks a defective cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run; accepted when idle or done |
| userLen | input | 13 | User block length in cells, at least 1 |
| margin | input | 6 | Correction capability reserved for transient errors |
| codeT | input | 48 | Eight 6-bit t values, code i at bits [6i+5:6i] |
| codeRed | input | 104 | Eight 13-bit redundancy lengths, code i at bits [13i+12:13i] |
| rdAddr | output | 6 | Bitmap word address |
| rdData | input | 64 | Bitmap word at rdAddr, same cycle |
| cfgWe | output | 1 | Configuration record write strobe |
| cfgAddr | output | 7 | Record index (logical block number) |
| cfgData | output | 9 | {head word index[5:0], code index[2:0]} |
| done | output | 1 | Run finished |

## Verification
The assertions assume that `start` is pulsed only while the block is idle or done, and that `userLen`, `margin`, the code table and the bitmap do not change during a run. Under those conditions record addresses increase by one and segment heads strictly increase. The stimulus sets all of these inputs before the `start` pulse, holds them until `done`, and always uses a `userLen` of at least 1 so that every accepted segment moves the head forward. Random bitmaps of several densities, together with directed maps that place defects on the segment boundary, in one overloaded word, or nowhere, are compared record by record against a cell-level model of the allocation rules.

// File: rtl/segalloc_pkg.sv
package segalloc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NEWSEG,
    ST_SCAN,
    ST_SKIP,
    ST_DONE
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic initRun;
    logic newSeg;
    logic addWord;
    logic accept;
    logic selCode;
    logic skipBegin;
    logic skipStep;
    logic skipHit;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tailPastEnd;
    logic fullAvail;
    logic covered;
    logic coverable;
    logic endAfterAccept;
    logic wordHit;
    logic lastWord;
  } flags_t;

endpackage

// File: rtl/segalloc_dp.sv
module segalloc_dp
  import segalloc_pkg::*;
#(
  parameter int NUM_CELLS = 4096,
  parameter int WORD_W    = 64,
  parameter int NUM_CODES = 8,
  parameter int T_W       = 6,
  parameter int LEN_W     = 13
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          stb,
  input  logic [LEN_W-1:0]                 userLen,
  input  logic [T_W-1:0]                   margin,
  input  logic [NUM_CODES*T_W-1:0]         codeT,
  input  logic [NUM_CODES*LEN_W-1:0]       codeRed,
  input  logic [WORD_W-1:0]                rdData,
  output logic [$clog2(NUM_CELLS/WORD_W)-1:0] rdAddr,
  output logic [$clog2(NUM_CELLS/WORD_W):0]   cfgAddr,
  output logic [$clog2(NUM_CELLS/WORD_W)+$clog2(NUM_CODES)-1:0] cfgData,
  output flags_t                           flg
);

  localparam int NUM_WORDS = NUM_CELLS / WORD_W;
  localparam int SH        = $clog2(WORD_W);
  localparam int WA_W      = $clog2(NUM_WORDS);
  localparam int CIDX_W    = $clog2(NUM_CODES);
  localparam int EW        = LEN_W + 2;
  localparam logic [EW-1:0]   CELLS_E = EW'(NUM_CELLS);
  localparam logic [EW-1:0]   ALIGN_M = EW'(WORD_W - 1);
  localparam logic [WA_W:0]   LAST_W  = (WA_W+1)'(NUM_WORDS - 1);

  logic [EW-1:0]     headQ, tailQ, cntFullQ;
  logic [WA_W:0]     ptrQ, segQ;
  logic [T_W-1:0]    tCurQ;
  logic [CIDX_W-1:0] selQ;

  function automatic logic [EW-1:0] popc(input logic [WORD_W-1:0] v);
    logic [EW-1:0] s;
    s = '0;
    for (int i = 0; i < WORD_W; i++) s = s + EW'(v[i]);
    return s;
  endfunction

  logic [EW-1:0]     ptrCell, tailUp, defCnt, wordPop, partPop;
  logic [WORD_W-1:0] tailMask;
  logic [EW:0]       req;
  logic [T_W-1:0]    tMax, bestT;
  logic [LEN_W-1:0]  bestRed;
  logic [CIDX_W-1:0] bestIdx;
  logic              found;

  always_comb begin
    ptrCell  = EW'(ptrQ) << SH;
    tailMask = (WORD_W'(1) << tailQ[SH-1:0]) - WORD_W'(1);
    wordPop  = popc(rdData);
    partPop  = popc(rdData & tailMask);
    defCnt   = cntFullQ + partPop;
    req      = {1'b0, defCnt} + (EW+1)'(margin);
    tailUp   = (tailQ + ALIGN_M) & ~ALIGN_M;
  end

  // least-redundancy code that covers req; strict < keeps lowest index on ties
  always_comb begin
    tMax    = '0;
    found   = 1'b0;
    bestIdx = '0;
    bestT   = '0;
    bestRed = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (codeT[i*T_W +: T_W] > tMax) tMax = codeT[i*T_W +: T_W];
      if (((EW+1)'(codeT[i*T_W +: T_W]) >= req) &&
          (!found || (codeRed[i*LEN_W +: LEN_W] < bestRed))) begin
        found   = 1'b1;
        bestIdx = CIDX_W'(i);
        bestT   = codeT[i*T_W +: T_W];
        bestRed = codeRed[i*LEN_W +: LEN_W];
      end
    end
  end

  always_comb begin
    flg.tailPastEnd    = tailQ > CELLS_E;
    flg.fullAvail      = (ptrCell + EW'(WORD_W)) <= tailQ;
    flg.covered        = (EW+1)'(tCurQ) >= req;
    flg.coverable      = req <= (EW+1)'(tMax);
    flg.endAfterAccept = tailUp >= CELLS_E;
    flg.wordHit        = |rdData;
    flg.lastWord       = ptrQ == LAST_W;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ    <= '0;
      tailQ    <= '0;
      cntFullQ <= '0;
      ptrQ     <= '0;
      segQ     <= '0;
      tCurQ    <= '0;
      selQ     <= '0;
    end else begin
      if (stb.initRun) begin
        headQ <= '0;
        segQ  <= '0;
      end
      if (stb.newSeg) begin
        tailQ    <= headQ + EW'(userLen);
        tCurQ    <= '0;
        selQ     <= '0;
        cntFullQ <= '0;
        ptrQ     <= headQ[SH +: WA_W+1];
      end
      if (stb.addWord) begin
        cntFullQ <= cntFullQ + wordPop;
        ptrQ     <= ptrQ + (WA_W+1)'(1);
      end
      if (stb.selCode) begin
        selQ  <= bestIdx;
        tCurQ <= bestT;
        tailQ <= headQ + EW'(userLen) + EW'(bestRed);
      end
      if (stb.accept) begin
        headQ <= tailUp;
        segQ  <= segQ + (WA_W+1)'(1);
      end
      if (stb.skipBegin) ptrQ <= headQ[SH +: WA_W+1];
      if (stb.skipStep)  ptrQ <= ptrQ + (WA_W+1)'(1);
      if (stb.skipHit)   headQ <= (EW'(ptrQ) + EW'(1)) << SH;
    end
  end

  assign rdAddr  = ptrQ[WA_W-1:0];
  assign cfgAddr = segQ;
  assign cfgData = {headQ[SH +: WA_W], selQ};

endmodule

// File: rtl/segalloc_ctrl.sv
module segalloc_ctrl
  import segalloc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  flags_t  flg,
  output strobe_t stb,
  output logic    done
);

  state_t stQ, stD;

  always_comb begin
    stD = stQ;
    stb = '0;
    unique case (stQ)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stb.initRun = 1'b1;
          stD = ST_NEWSEG;
        end
      end
      ST_NEWSEG: begin
        stb.newSeg = 1'b1;
        stD = ST_SCAN;
      end
      ST_SCAN: begin
        if (flg.tailPastEnd) begin
          stD = ST_DONE;
        end else if (flg.fullAvail) begin
          stb.addWord = 1'b1;
        end else if (flg.covered) begin
          stb.accept = 1'b1;
          stD = flg.endAfterAccept ? ST_DONE : ST_NEWSEG;
        end else if (flg.coverable) begin
          stb.selCode = 1'b1;
        end else begin
          stb.skipBegin = 1'b1;
          stD = ST_SKIP;
        end
      end
      ST_SKIP: begin
        if (flg.wordHit) begin
          stb.skipHit = 1'b1;
          stD = flg.lastWord ? ST_DONE : ST_NEWSEG;
        end else if (flg.lastWord) begin
          stD = ST_DONE;
        end else begin
          stb.skipStep = 1'b1;
        end
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  assign done = stQ == ST_DONE;

endmodule

// File: rtl/segment_allocator.sv
module segment_allocator
  import segalloc_pkg::*;
#(
  parameter int NUM_CELLS = 4096,
  parameter int WORD_W    = 64,
  parameter int NUM_CODES = 8,
  parameter int T_W       = 6,
  parameter int LEN_W     = 13
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  start,
  input  logic [LEN_W-1:0]                      userLen,
  input  logic [T_W-1:0]                        margin,
  input  logic [NUM_CODES*T_W-1:0]              codeT,
  input  logic [NUM_CODES*LEN_W-1:0]            codeRed,
  output logic [$clog2(NUM_CELLS/WORD_W)-1:0]   rdAddr,
  input  logic [WORD_W-1:0]                     rdData,
  output logic                                  cfgWe,
  output logic [$clog2(NUM_CELLS/WORD_W):0]     cfgAddr,
  output logic [$clog2(NUM_CELLS/WORD_W)+$clog2(NUM_CODES)-1:0] cfgData,
  output logic                                  done
);

  strobe_t stb;
  flags_t  flg;

  segalloc_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .flg   (flg),
    .stb   (stb),
    .done  (done)
  );

  segalloc_dp #(
    .NUM_CELLS (NUM_CELLS),
    .WORD_W    (WORD_W),
    .NUM_CODES (NUM_CODES),
    .T_W       (T_W),
    .LEN_W     (LEN_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .userLen (userLen),
    .margin  (margin),
    .codeT   (codeT),
    .codeRed (codeRed),
    .rdData  (rdData),
    .rdAddr  (rdAddr),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .flg     (flg)
  );

  assign cfgWe = stb.accept;

endmodule

// File: rtl/segment_allocator_chk.sv
module segment_allocator_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 9,
  parameter int HW     = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              cfgWe,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [DATA_W-1:0] cfgData
);

  logic [ADDR_W-1:0] expAddr;
  logic [HW-1:0]     lastHead;
  logic [HW-1:0]     headW;

  assign headW = cfgData[DATA_W-1 -: HW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expAddr  <= '0;
      lastHead <= '0;
    end else if (start) begin
      expAddr  <= '0;
      lastHead <= '0;
    end else if (cfgWe) begin
      expAddr  <= expAddr + ADDR_W'(1);
      lastHead <= headW;
    end
  end

  AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> !done); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R1

  AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> cfgAddr == expAddr); // R2

  AST_HEAD_RISES: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && expAddr != '0) |-> headW > lastHead); // R3

endmodule

bind segment_allocator segment_allocator_chk #(
  .ADDR_W ($clog2(NUM_CELLS/WORD_W) + 1),
  .DATA_W ($clog2(NUM_CELLS/WORD_W) + $clog2(NUM_CODES)),
  .HW     ($clog2(NUM_CELLS/WORD_W))
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .done    (done),
  .cfgWe   (cfgWe),
  .cfgAddr (cfgAddr),
  .cfgData (cfgData)
);

// File: tb/segment_allocator_tb.sv
module segment_allocator_tb;

  localparam int NC    = 4096;
  localparam int WW    = 64;
  localparam int NW    = NC / WW;
  localparam int NCODE = 8;
  localparam int TW    = 6;
  localparam int LW    = 13;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [LW-1:0]     userLen = '0;
  logic [TW-1:0]     margin = '0;
  logic [NCODE*TW-1:0] codeT;
  logic [NCODE*LW-1:0] codeRed;
  logic [5:0]        rdAddr;
  logic [WW-1:0]     rdData;
  logic              cfgWe;
  logic [6:0]        cfgAddr;
  logic [8:0]        cfgData;
  logic              done;

  logic [WW-1:0] mem [NW];
  int tT [NCODE];
  int tR [NCODE];

  int nChk = 0;
  int nBad = 0;

  int gotN, expN;
  int gotHead [NW+1];
  int gotCode [NW+1];
  int expHead [NW+1];
  int expCode [NW+1];
  bit collecting = 1'b0;

  always #5 clk = ~clk;

  assign rdData = mem[rdAddr];

  always_comb begin
    for (int i = 0; i < NCODE; i++) begin
      codeT[i*TW +: TW]   = TW'(tT[i]);
      codeRed[i*LW +: LW] = LW'(tR[i]);
    end
  end

  segment_allocator u_dut (
    .clk(clk), .rstN(rstN), .start(start), .userLen(userLen), .margin(margin),
    .codeT(codeT), .codeRed(codeRed), .rdAddr(rdAddr), .rdData(rdData),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .done(done)
  );

  always @(negedge clk) begin
    if (collecting && cfgWe && gotN <= NW) begin
      gotHead[gotN] = int'(cfgData[8:3]);
      gotCode[gotN] = int'(cfgData[2:0]);
      gotN++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit cellBad(input int c);
    return mem[c / WW][c % WW];
  endfunction

  task automatic clearMap();
    for (int w = 0; w < NW; w++) mem[w] = '0;
  endtask

  task automatic tableStd();
    // index 0 strongest, index 7 weakest
    for (int i = 0; i < NCODE; i++) begin
      tT[i] = (i == 0) ? 15 : (i == 1) ? 11 : (i == 2) ? 8 : (i == 3) ? 6 : (8 - i);
      tR[i] = 11 * tT[i];
    end
  endtask

  // cell-level model of the allocation rules
  task automatic refRun();
    int head, tail, tcur, sel, req, cnt, tmax, best, p;
    bit segDone;
    expN = 0;
    tmax = 0;
    for (int i = 0; i < NCODE; i++) if (tT[i] > tmax) tmax = tT[i];
    head = 0;
    while (head < NC) begin
      tail = head + int'(userLen);
      tcur = 0;
      sel = 0;
      segDone = 1'b0;
      while (!segDone) begin
        if (tail > NC) return;
        cnt = 0;
        for (int c = head; c < tail; c++) cnt += int'(cellBad(c));
        req = cnt + int'(margin);
        if (tcur >= req) begin
          expHead[expN] = head / WW;
          expCode[expN] = sel;
          expN++;
          head = ((tail + WW - 1) / WW) * WW;
          segDone = 1'b1;
        end else if (req <= tmax) begin
          best = -1;
          for (int i = 0; i < NCODE; i++)
            if (tT[i] >= req && (best < 0 || tR[i] < tR[best])) best = i;
          sel = best;
          tcur = tT[best];
          tail = head + int'(userLen) + tR[best];
        end else begin
          p = -1;
          for (int c = head; c < NC && p < 0; c++) if (cellBad(c)) p = c;
          if (p < 0) return;
          head = ((p + WW) / WW) * WW;
          segDone = 1'b1;
        end
      end
    end
  endtask

  task automatic runDut();
    int cyc;
    gotN = 0;
    collecting = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 50000) begin
      @(negedge clk);
      cyc++;
    end
    collecting = 1'b0;
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
    end
  endtask

  task automatic compareAll(input string tag);
    int n;
    refRun();
    check({tag, " R7 record count"}, gotN, expN);
    n = (gotN < expN) ? gotN : expN;
    for (int i = 0; i < n; i++) begin
      check({tag, " R3 R6 head"}, gotHead[i], expHead[i]);
      check({tag, " R4 R8 code"}, gotCode[i], expCode[i]);
    end
  endtask

  task automatic tReset();
    check("R1 done after reset", int'(done), 0);
    check("R1 no write after reset", int'(cfgWe), 0);
  endtask

  task automatic tClean();
    clearMap();
    tableStd();
    userLen = 13'd100;
    margin = '0;
    runDut();
    check("R5 clean segment count", gotN, 32);
    for (int i = 0; i < gotN; i++) begin
      check("R3 clean head word", gotHead[i], 2 * i);
      check("R5 clean code index", gotCode[i], 0);
    end
    repeat (5) @(negedge clk);
    check("R1 done held", int'(done), 1);
    check("R1 no later writes", gotN, 32);
  endtask

  task automatic tBoundary();
    clearMap();
    tableStd();
    userLen = 13'd100;
    margin = '0;
    mem[1][36] = 1'b1;           // cell 100, first cell past the segment
    runDut();
    check("R9 defect past end ignored", gotCode[0], 0);
    check("R10 R9 head", gotHead[0], 0);
    clearMap();
    mem[1][35] = 1'b1;           // cell 99, last cell of the segment
    runDut();
    check("R9 last cell counted, weakest code", gotCode[0], 7);
    check("R8 next head after 111 cells", gotHead[1], 2);
  endtask

  task automatic tTie();
    clearMap();
    tT = '{1, 3, 3, 6, 8, 10, 15, 4};
    tR = '{11, 33, 33, 66, 88, 110, 165, 33};
    userLen = 13'd100;
    margin = 6'd2;
    runDut();
    check("R4 tie picks lowest index", gotCode[0], 1);
    margin = 6'd4;
    runDut();
    check("R4 cheapest code not monotone", gotCode[0], 7);
    compareAll("tie");
  endtask

  task automatic tSkip();
    clearMap();
    tableStd();
    userLen = 13'd100;
    margin = '0;
    for (int b = 0; b < 20; b++) mem[0][b*3] = 1'b1;
    runDut();
    check("R6 skip past overloaded word", gotHead[0], 1);
    check("R6 skipped segment code", gotCode[0], 0);
    compareAll("skip");
  endtask

  task automatic tEnd();
    clearMap();
    tableStd();
    margin = '0;
    userLen = 13'd4096;
    runDut();
    check("R7 exact fit written", gotN, 1);
    userLen = 13'd4097;
    runDut();
    check("R7 overrun not written", gotN, 0);
    check("R7 done after overrun", int'(done), 1);
  endtask

  task automatic tRandom(input int dens, input int mg, input int len);
    clearMap();
    tableStd();
    userLen = LW'(len);
    margin = TW'(mg);
    for (int w = 0; w < NW; w++)
      for (int b = 0; b < WW; b++)
        mem[w][b] = (($urandom % 1000) < dens);
    runDut();
    compareAll("random");
  endtask

  initial begin
    void'($urandom(7));
    tableStd();
    clearMap();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tClean();
    tBoundary();
    tTie();
    tSkip();
    tEnd();
    tRandom(10, 1, 200);
    tRandom(40, 2, 300);
    tRandom(90, 0, 120);
    tRandom(25, 3, 500);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule